// File: doc/BRIEF.md
# Programmable Three-Channel Matrix Color Converter

This block converts a stream of three-component pixels, eight bits per component, through a programmable 3x3 matrix. A per-channel offset is added and a shared power-of-two scale is applied. The full-precision result is rounded and clamped back to eight bits. The clamp is either the full code range or, when requested, video range. One coefficient set gives RGB to YCbCr, another YCbCr to RGB, and an identity matrix passes pixels through unchanged. Which set is loaded is up to the surrounding logic.

Configuration arrives as six packed 32-bit words on a write port carrying a word index and the data. Writes land in a shadow copy. That copy is moved into the working set only on a frame-start pulse, so a frame is never converted with a half-written matrix. Pixels enter and leave over valid/ready handshakes. A fixed three-stage pipeline sits between them and stalls as a whole when the consumer holds off.

Top module: `pixel_matrix_converter`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. Both the working and the shadow parameter sets hold the pass-through setting: diagonal coefficients 128, all others 0, offsets 0, scale code 2, saturation off.
- R2: Each output channel i equals 2^(s-1) * (sum over j of c[i][j]*in[j] / 256 + a[i] / 4). Here c is a 9-bit two's-complement coefficient, a is a 13-bit two's-complement offset and s is the 2-bit scale code, so code 0 halves and code 3 quadruples. Channel 0 sits in pixel bits 7:0, channel 1 in 15:8 and channel 2 in 23:16.
- R3: The result is computed at full precision and rounded half up, toward positive infinity on an exact half, before clamping.
- R4: With the saturation flag clear, every output channel is clamped to 0..255.
- R5: With the saturation flag set, channel 0 is clamped to 16..235 and channels 1 and 2 to 16..240.
- R6: Words 0, 2 and 4 each hold the low five bits of an offset in bits 31:27, plus three coefficients in bits 26:18, 17:9 and 8:0. Word 0 holds a[0], c00, c11 and c22. Word 2 holds a[1], c01, c10 and c20. Word 4 holds a[2], c02, c12 and c21, in that slot order.
- R7: Words 1, 3 and 5 hold offset bits 12:5 of a[0], a[1] and a[2] in bits 7:0. Word 1 also holds the scale code in bits 9:8 and the saturation flag in bit 10. Writes to word indices 6 and 7 change nothing.
- R8: A parameter write alters no output until the next frame-start pulse. A pixel accepted in the same cycle as the pulse still uses the previous set. A write made in the pulse cycle goes only to the shadow set.
- R9: With out_ready held high, a pixel accepted in one cycle appears on out_valid/out_pix exactly three cycles later.
- R10: While out_valid is high and out_ready is low, out_pix holds steady and in_ready is low. No pixel is lost or duplicated, and at most three pixels are in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_idx | input | 3 | Parameter word index (0..5 used) |
| cfg_data | input | 32 | Parameter word data |
| frame_start | input | 1 | Frame boundary pulse; moves shadow set to working set |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 24 | Input pixel, channel 0 in bits 7:0 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_pix | output | 24 | Output pixel, channel 0 in bits 7:0 |

## Verification
The hardest situation to reach is a change of parameter set while pixels are still in the pipeline and the output is stalled. In that case a stage that read its controls from the working set, rather than carrying them, would convert an in-flight pixel with a mix of old and new values. The random phase gets there by issuing frame-start pulses and writes to random word indices in the middle of a stream, while out_ready toggles at random. The reference model tags every accepted pixel with the set in force in its acceptance cycle. A directed phase also places a pulse, a write and an accepted pixel in one cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PIX_W     = 8;
  localparam int NCH       = 3;
  localparam int COEF_W    = 9;
  localparam int OFS_W     = 13;
  localparam int SCL_W     = 2;
  localparam int WORD_W    = 32;
  localparam int NWORD     = 6;
  localparam int IDX_W     = 3;
  localparam int COEF_FRAC = 8;
  localparam int OFS_FRAC  = 2;
  localparam int OFS_LO_W  = 5;
  localparam int OFS_HI_W  = OFS_W - OFS_LO_W;
  localparam int SLOT_HI   = 2 * COEF_W;
  localparam int SLOT_MID  = COEF_W;
  localparam int SCL_LSB   = OFS_HI_W;
  localparam int SAT_BIT   = SCL_LSB + SCL_W;
  localparam int PROD_W    = COEF_W + PIX_W + 1;
  localparam int ACC_W     = PROD_W + 3;
  localparam int PIPE_LAT  = 3;
  localparam int UNITY     = 1 << (COEF_FRAC - 1);

  typedef struct packed {
    logic [NCH-1:0][NCH-1:0][COEF_W-1:0] c;
    logic [NCH-1:0][OFS_W-1:0]           a;
    logic [SCL_W-1:0]                    scale;
    logic                                sat;
  } cfg_t;

  function automatic cfg_t cfg_identity();
    cfg_t r;
    r = '0;
    for (int i = 0; i < NCH; i++) r.c[i][i] = COEF_W'(UNITY);
    r.scale = SCL_W'(2);
    return r;
  endfunction

  function automatic int mid_col(input int k);
    return (k == 0) ? 1 : (k == 1) ? 0 : 2;
  endfunction

  function automatic int low_col(input int k);
    return (k == 0) ? 2 : (k == 1) ? 0 : 1;
  endfunction
endpackage

// File: rtl/pmc_cfg_bank.sv
module pmc_cfg_bank
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              frame_start,
  output cfg_t              active
);
  cfg_t shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= cfg_identity();
      active <= cfg_identity();
    end else begin
      if (frame_start) active <= shadow;
      if (cfg_we) begin
        for (int k = 0; k < NCH; k++) begin
          if (cfg_idx == IDX_W'(2 * k)) begin
            shadow.a[k][OFS_LO_W-1:0]  <= cfg_data[WORD_W-1 -: OFS_LO_W];
            shadow.c[0][k]             <= cfg_data[SLOT_HI +: COEF_W];
            shadow.c[1][mid_col(k)]    <= cfg_data[SLOT_MID +: COEF_W];
            shadow.c[2][low_col(k)]    <= cfg_data[0 +: COEF_W];
          end else if (cfg_idx == IDX_W'(2 * k + 1)) begin
            shadow.a[k][OFS_W-1:OFS_LO_W] <= cfg_data[OFS_HI_W-1:0];
            if (k == 0) begin
              shadow.scale <= cfg_data[SCL_LSB +: SCL_W];
              shadow.sat   <= cfg_data[SAT_BIT];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pmc_lane.sv
module pmc_lane
  import pmc_pkg::*;
#(
  parameter bit LUMA = 1'b0
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [NCH-1:0][PIX_W-1:0]     pix,
  input  logic [NCH-1:0][COEF_W-1:0]    row,
  input  logic [OFS_W-1:0]              ofs,
  input  logic [SCL_W-1:0]              scale_s2,
  input  logic                          sat_s2,
  output logic [PIX_W-1:0]              res
);
  localparam logic signed [ACC_W-1:0] LO_RAW = ACC_W'(0);
  localparam logic signed [ACC_W-1:0] HI_RAW = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] LO_SAT = ACC_W'(16);
  localparam logic signed [ACC_W-1:0] HI_Y   = ACC_W'(235);
  localparam logic signed [ACC_W-1:0] HI_C   = ACC_W'(240);

  // stage 1: products
  logic signed [PROD_W-1:0] prod_q [NCH];
  logic signed [OFS_W-1:0]  ofs_q;

  always_ff @(posedge clk) begin
    if (en) begin
      for (int j = 0; j < NCH; j++)
        prod_q[j] <= $signed(row[j]) * $signed({1'b0, pix[j]});
      ofs_q <= $signed(ofs);
    end
  end

  // stage 2: sum in 1/256 units
  logic signed [ACC_W-1:0] acc_d, acc_q;

  always_comb begin
    acc_d = ACC_W'(ofs_q) <<< (COEF_FRAC - OFS_FRAC);
    for (int j = 0; j < NCH; j++) acc_d = acc_d + ACC_W'(prod_q[j]);
  end

  always_ff @(posedge clk) begin
    if (en) acc_q <= acc_d;
  end

  // stage 3: scale, round half up, clamp
  logic signed [ACC_W-1:0] half, rnd, lo_w, hi_w;
  logic [PIX_W-1:0]        res_d;
  int                      sh;

  always_comb begin
    sh   = COEF_FRAC + 1 - int'(scale_s2);
    half = ACC_W'(1) <<< (sh - 1);
    rnd  = (acc_q + half) >>> sh;
    lo_w = sat_s2 ? LO_SAT : LO_RAW;
    hi_w = sat_s2 ? (LUMA ? HI_Y : HI_C) : HI_RAW;
    if (rnd < lo_w)      res_d = lo_w[PIX_W-1:0];
    else if (rnd > hi_w) res_d = hi_w[PIX_W-1:0];
    else                 res_d = rnd[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) res <= res_d;
  end
endmodule

// File: rtl/pixel_matrix_converter.sv
module pixel_matrix_converter
  import pmc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [WORD_W-1:0]      cfg_data,
  input  logic                   frame_start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NCH*PIX_W-1:0]   in_pix,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NCH*PIX_W-1:0]   out_pix
);
  cfg_t                       active;
  logic                       en;
  logic [PIPE_LAT-1:0]        vld_q;
  logic [SCL_W-1:0]           scale_s1, scale_s2;
  logic                       sat_s1, sat_s2, sat_q;
  logic [NCH-1:0][PIX_W-1:0]  pix_in;
  logic [NCH-1:0][PIX_W-1:0]  pix_out;

  pmc_cfg_bank u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .frame_start(frame_start), .active(active)
  );

  assign en        = !vld_q[PIPE_LAT-1] || out_ready;
  assign in_ready  = en;
  assign out_valid = vld_q[PIPE_LAT-1];
  assign pix_in    = in_pix;
  assign out_pix   = pix_out;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (en) vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
  end

  // scale and saturation travel with the pixel
  always_ff @(posedge clk) begin
    if (rst) begin
      scale_s1 <= '0; scale_s2 <= '0;
      sat_s1 <= 1'b0; sat_s2 <= 1'b0; sat_q <= 1'b0;
    end else if (en) begin
      scale_s1 <= active.scale;
      sat_s1   <= active.sat;
      scale_s2 <= scale_s1;
      sat_s2   <= sat_s1;
      sat_q    <= sat_s2;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    pmc_lane #(.LUMA(i == 0)) u_lane (
      .clk(clk), .en(en), .pix(pix_in), .row(active.c[i]),
      .ofs(active.a[i]), .scale_s2(scale_s2), .sat_s2(sat_s2),
      .res(pix_out[i])
    );
  end
endmodule

// File: rtl/pmc_check.sv
module pmc_check
  import pmc_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NCH*PIX_W-1:0] out_pix,
  input logic                 sat_q
);
  logic [1:0] age;
  logic [2:0] occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
      occ <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_occupancy_r10: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'(PIPE_LAT));

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1))
      |-> out_valid);

  p_sat_range_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sat_q) |->
      (out_pix[7:0] >= 8'd16 && out_pix[7:0] <= 8'd235 &&
       out_pix[15:8] >= 8'd16 && out_pix[15:8] <= 8'd240 &&
       out_pix[23:16] >= 8'd16 && out_pix[23:16] <= 8'd240));
endmodule

bind pixel_matrix_converter pmc_check u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .sat_q(sat_q)
);

// File: tb/sim_pixel_matrix_converter.sv
`timescale 1ns/1ps
module sim_pixel_matrix_converter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_we, frame_start, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_data;
  logic [23:0] in_pix, out_pix;

  pixel_matrix_converter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] sh_w [6];
  logic [31:0] cur_w [6];
  logic [31:0] nw [6];
  logic [23:0] exp_q [$];
  int          acc_q [$];
  string       tag = "R1";
  bit          lat_chk = 0, last_acc = 0, prev_stall = 0, done = 0;
  logic [23:0] prev_pix;
  int pc [3][3];
  int pa [3];
  int ps, psat;

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [23:0] ref_pix(input logic [31:0] w [6], input logic [23:0] p);
    int c [3][3];
    int a [3];
    int s, t, k, r, lo, hi;
    bit st;
    logic [23:0] o;
    c[0][0] = sx(int'(w[0][26:18]), 9); c[1][1] = sx(int'(w[0][17:9]), 9); c[2][2] = sx(int'(w[0][8:0]), 9);
    c[0][1] = sx(int'(w[2][26:18]), 9); c[1][0] = sx(int'(w[2][17:9]), 9); c[2][0] = sx(int'(w[2][8:0]), 9);
    c[0][2] = sx(int'(w[4][26:18]), 9); c[1][2] = sx(int'(w[4][17:9]), 9); c[2][1] = sx(int'(w[4][8:0]), 9);
    for (int i = 0; i < 3; i++) a[i] = sx(int'({w[2*i+1][7:0], w[2*i][31:27]}), 13);
    s  = int'(w[1][9:8]);
    st = w[1][10];
    for (int i = 0; i < 3; i++) begin
      t = c[i][0] * int'(p[7:0]) + c[i][1] * int'(p[15:8]) + c[i][2] * int'(p[23:16]) + a[i] * 64;
      k = 9 - s;
      r = (t + (1 << (k - 1))) >>> k;
      lo = st ? 16 : 0;
      hi = st ? ((i == 0) ? 235 : 240) : 255;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      o[8*i +: 8] = 8'(r);
    end
    return o;
  endfunction

  task automatic mk_words();
    for (int i = 0; i < 6; i++) nw[i] = '0;
    nw[0] = {5'(pa[0]), 9'(pc[0][0]), 9'(pc[1][1]), 9'(pc[2][2])};
    nw[2] = {5'(pa[1]), 9'(pc[0][1]), 9'(pc[1][0]), 9'(pc[2][0])};
    nw[4] = {5'(pa[2]), 9'(pc[0][2]), 9'(pc[1][2]), 9'(pc[2][1])};
    nw[1] = {21'd0, 1'(psat), 2'(ps), 8'(pa[0] >>> 5)};
    nw[3] = {24'd0, 8'(pa[1] >>> 5)};
    nw[5] = {24'd0, 8'(pa[2] >>> 5)};
  endtask

  task automatic fail(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic step();
    logic [23:0] e;
    int ac;
    #2;
    if (prev_stall) begin
      n_chk++;
      if (!(out_valid && out_pix == prev_pix)) fail("R10", "stalled output moved", {7'd0, out_valid, out_pix}, {8'h01, prev_pix});
    end
    if (out_valid && !out_ready) begin
      n_chk++;
      if (in_ready) fail("R10", "in_ready during stall", 32'(in_ready), 32'd0);
    end
    prev_stall = out_valid && !out_ready;
    prev_pix   = out_pix;
    if (out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) fail("R10", "unexpected output", 32'(out_pix), 32'd0);
      else begin
        e  = exp_q.pop_front();
        ac = acc_q.pop_front();
        if (out_pix !== e) fail(tag, "pixel", 32'(out_pix), 32'(e));
        if (lat_chk) begin
          n_chk++;
          if (cyc - ac != 3) fail("R9", "latency", 32'(cyc - ac), 32'd3);
        end
      end
    end
    last_acc = in_valid && in_ready;
    if (last_acc) begin
      exp_q.push_back(ref_pix(cur_w, in_pix));
      acc_q.push_back(cyc);
    end
    if (frame_start) cur_w = sh_w;
    if (cfg_we && cfg_idx < 3'd6) sh_w[cfg_idx] = cfg_data;
    cyc++;
    @(negedge clk);
  endtask

  task automatic send(input logic [23:0] p);
    in_valid = 1'b1; in_pix = p;
    step();
    while (!last_acc) step();
    in_valid = 1'b0;
  endtask

  task automatic write_words(input bit pulse);
    for (int i = 0; i < 6; i++) begin
      cfg_we = 1'b1; cfg_idx = 3'(i); cfg_data = nw[i];
      step();
    end
    cfg_we = 1'b0;
    if (pulse) begin
      frame_start = 1'b1; step(); frame_start = 1'b0;
    end
  endtask

  task automatic drain();
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (8) step();
    n_chk++;
    if (exp_q.size() != 0) fail("R10", "pixels lost", 32'(exp_q.size()), 32'd0);
    exp_q.delete(); acc_q.delete();
  endtask

  task automatic clear_params();
    for (int i = 0; i < 3; i++) begin
      pa[i] = 0;
      for (int j = 0; j < 3; j++) pc[i][j] = 0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    fail("R10", "watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0c5c));
    rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_data = 0; frame_start = 0;
    in_valid = 0; in_pix = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    n_chk++; if (out_valid !== 1'b0) fail("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    n_chk++; if (in_ready !== 1'b1) fail("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst = 1'b0;
    clear_params();
    for (int i = 0; i < 3; i++) pc[i][i] = 128;
    ps = 2; psat = 0;
    mk_words();
    sh_w = nw; cur_w = nw;

    // R1 pass-through after reset, R9 latency
    tag = "R1"; lat_chk = 1;
    send(24'h000000); send(24'h0180FF); send(24'h63C811);
    for (int i = 0; i < 6; i++) send(24'($urandom));
    drain();
    lat_chk = 0;

    // R3 rounding half up
    tag = "R3";
    clear_params(); pc[0][0] = 128; pa[1] = -2; pa[2] = 6; ps = 1; psat = 0;
    mk_words(); write_words(1);
    send(24'h000001); send(24'h000003); send(24'h000000); send(24'h0000FF);
    drain();

    // R4 full-range clamp
    tag = "R4";
    clear_params();
    for (int j = 0; j < 3; j++) begin pc[0][j] = 255; pc[1][j] = -256; end
    pc[2][0] = 100; pc[2][1] = -50; pc[2][2] = 30;
    pa[0] = 4095; pa[1] = -4096; ps = 3; psat = 0;
    mk_words(); write_words(1);
    send(24'hFFFFFF); send(24'h000000); send(24'h1E140A); send(24'h00FF00);
    drain();

    // R5 video-range clamp
    tag = "R5";
    psat = 1; ps = 1; pa[2] = 4095;
    mk_words(); write_words(1);
    send(24'h000000); send(24'hFFFFFF);
    for (int i = 0; i < 6; i++) send(24'($urandom));
    drain();

    // R6 and R7 packing with distinct coefficients
    tag = "R6";
    pc[0][0] = 77;  pc[0][1] = 150; pc[0][2] = 29;
    pc[1][0] = -43; pc[1][1] = -85; pc[1][2] = 128;
    pc[2][0] = 128; pc[2][1] = -107; pc[2][2] = -21;
    pa[0] = 0; pa[1] = 512; pa[2] = 512; ps = 1; psat = 0;
    mk_words(); write_words(1);
    for (int i = 0; i < 12; i++) send(24'($urandom));
    drain();

    // R2 half scale and odd offsets
    tag = "R2";
    pc[0][1] = 201; pc[1][2] = -3; pc[2][0] = 255;
    pa[0] = -100; pa[1] = 300; pa[2] = 37; ps = 0;
    mk_words(); write_words(1);
    for (int i = 0; i < 12; i++) send(24'($urandom));
    drain();

    // R8 shadowing; R7 writes to unused indices
    tag = "R8";
    clear_params();
    pc[0][2] = 128; pc[1][0] = 128; pc[2][1] = 128; ps = 2; psat = 1;
    mk_words(); write_words(0);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_data = 32'hFFFF_FFFF; step();
    cfg_idx = 3'd7; cfg_data = 32'h0000_07FF; step();
    cfg_we = 1'b0;
    for (int i = 0; i < 5; i++) send(24'($urandom));
    frame_start = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd1; cfg_data = 32'h0000_0100;
    send(24'h8040C0);
    frame_start = 1'b0; cfg_we = 1'b0;
    tag = "R7";
    for (int i = 0; i < 5; i++) send(24'($urandom));
    frame_start = 1'b1; step(); frame_start = 1'b0;
    tag = "R8";
    for (int i = 0; i < 5; i++) send(24'($urandom));
    drain();

    // R10 backpressure
    tag = "R10";
    for (int i = 0; i < 60; i++) begin
      in_valid = 1'b1; in_pix = 24'($urandom); out_ready = 1'($urandom % 2);
      step();
    end
    drain();

    // R2 random stream with mid-stream parameter traffic
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      in_valid    = ($urandom % 100) < 70;
      in_pix      = 24'($urandom);
      out_ready   = ($urandom % 100) < 60;
      cfg_we      = ($urandom % 16) == 0;
      cfg_idx     = 3'($urandom % 8);
      cfg_data    = $urandom;
      frame_start = ($urandom % 64) == 0;
      step();
    end
    cfg_we = 1'b0; frame_start = 1'b0;
    drain();

    summary();
  end
endmodule